// File: doc/BRIEF.md
# Flexible Immediate Operand Codec

The codec takes a 32-bit value and decides whether it can travel as a compact 12-bit immediate for a data-processing operation. A value qualifies if it matches one of four shapes. The first shape is an 8-bit field placed at any bit position. The other three are byte-replication patterns: the byte repeated in lanes 0 and 2 with zeros elsewhere, the byte repeated in lanes 1 and 3 with zeros elsewhere, and the byte repeated in every lane. When a value qualifies, the block emits one canonical 12-bit code for it. A decoder inside the block expands that registered code back to 32 bits, so the response can be compared with the request.

A request is a single 32-bit word qualified by `req_valid`. The block is always ready, and any cycle with `req_valid` high is an accepted request. The response registers load on the clock edge that accepts the request and are visible in the next cycle under `rsp_valid`.

A two-state controller tracks whether the response registers hold a fresh result:
- **ST_IDLE**: no fresh response is available.
- **ST_RESULT**: the response registers hold the result of the request accepted on the previous edge.

The controller has two transitions:
- **take**: `req_valid` is high, and the next state is ST_RESULT, from either state.
- **drain**: `req_valid` is low, and the next state is ST_IDLE, from either state.

Synchronous reset forces ST_IDLE and clears the response fields.

Top module: `imm_operand_codec`

## Requirements
- R1: A value below 256 is encodable, with code bits [11:8] = 0 and bits [7:0] = the value.
- R2: A value of the form 0x00BB00BB that is not covered by R1 is encodable with code = {4'd1, BB}.
- R3: A value of the form 0xBB00BB00 that is not covered by R1 is encodable with code = {4'd2, BB}.
- R4: A value of the form 0xBBBBBBBB that is not covered by R1 is encodable with code = {4'd4-1, BB}, that is selector 3.
- R5: A value not covered by R1 to R4 is encodable if it equals an 8-bit seed {1, p[6:0]} rotated right by an amount n in 8..31. The code is {n[4:0], p[6:0]}, so code bits [11:10] are never 00. If several n fit, the smallest n is used.
- R6: A zero input gives rsp_ok = 1 and a code of all zeros. Overlapping forms resolve in the order R1, R2, R3, R4, R5.
- R7: A value that fits no form gives rsp_ok = 0 and rsp_code = 0.
- R8: rsp_expanded is the expansion of rsp_code. It equals the accepted value whenever rsp_ok = 1, and it is 0 when rsp_ok = 0.
- R9: req_ready is always 1. rsp_valid is high exactly in the cycle after a cycle with req_valid high. Synchronous reset (rst_n low) clears rsp_valid, rsp_ok and rsp_code.
- R10: In a cycle without an accepted request, rsp_ok and rsp_code keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always high |
| req_value | input | 32 | Value to encode |
| rsp_valid | output | 1 | Response is fresh this cycle |
| rsp_ok | output | 1 | Value is encodable |
| rsp_code | output | 12 | Canonical 12-bit code, or zero |
| rsp_expanded | output | 32 | Decoder output for rsp_code |

## Verification
The bench builds the codec with its defaults: a 32-bit word, 8-bit bytes and a 12-bit code. At this size the full input space cannot be swept, so the stimulus is built from the shape of each form:
- all 256 plain values;
- every seed payload at every rotation amount from 8 to 31;
- the three replication patterns for a spread of bytes;
- near-miss values that fail by one bit;
- values produced by expanding random codes;
- raw random words.

Idle gaps with changing inputs between requests show that the held response is unaffected. A reset issued in the middle of the run shows the response valid being cleared.

// File: rtl/imm_codec_pkg.sv
package imm_codec_pkg;

    // Replication selector values; the order is also the match priority.
    typedef enum logic [1:0] {
        FORM_PLAIN  = 2'd0,
        FORM_LANE02 = 2'd1,
        FORM_LANE13 = 2'd2,
        FORM_ALL    = 2'd3
    } repl_form_e;

    // Response-register occupancy.
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } codec_state_e;

endpackage

// File: rtl/imm_repl_match.sv
module imm_repl_match #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              even_rep_o,
    output logic              odd_rep_o,
    output logic              all_rep_o
);

    localparam int LANES = WORD_W / BYTE_W;

    logic [LANES-1:0] even_ok;
    logic [LANES-1:0] odd_ok;
    logic [LANES-1:0] all_ok;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [BYTE_W-1:0] lane_v;
            assign lane_v    = word_i[l*BYTE_W +: BYTE_W];
            assign all_ok[l] = (lane_v == word_i[BYTE_W-1:0]);
            if (l % 2 == 0) begin : g_even
                assign even_ok[l] = (lane_v == word_i[BYTE_W-1:0]);
                assign odd_ok[l]  = (lane_v == '0);
            end else begin : g_odd
                assign even_ok[l] = (lane_v == '0);
                assign odd_ok[l]  = (lane_v == word_i[2*BYTE_W-1:BYTE_W]);
            end
        end
    endgenerate

    assign even_rep_o = &even_ok;
    assign odd_rep_o  = &odd_ok;
    assign all_rep_o  = &all_ok;

endmodule

// File: rtl/imm_rot_search.sv
module imm_rot_search #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic [WORD_W-1:0]             word_i,
    output logic                          hit_o,
    output logic [$clog2(WORD_W)-1:0]     rot_o,
    output logic [BYTE_W-2:0]             frac_o
);

    localparam int ROT_W   = $clog2(WORD_W);
    localparam int ROT_MIN = WORD_W / 4;
    localparam int ROT_CNT = WORD_W - ROT_MIN;

    logic [ROT_CNT-1:0] cand;
    logic [BYTE_W-2:0]  frac [ROT_CNT];

    // One candidate per rotate amount: undo the rotation and test the seed shape.
    generate
        for (genvar k = 0; k < ROT_CNT; k++) begin : g_rot
            localparam int R = ROT_MIN + k;
            logic [WORD_W-1:0] undone;
            assign undone  = (word_i << R) | (word_i >> (WORD_W - R));
            assign cand[k] = (undone[WORD_W-1:BYTE_W] == '0) && undone[BYTE_W-1];
            assign frac[k] = undone[BYTE_W-2:0];
        end
    endgenerate

    // Scan from the largest amount down so the smallest matching amount wins.
    always_comb begin
        hit_o  = 1'b0;
        rot_o  = '0;
        frac_o = '0;
        for (int k = ROT_CNT - 1; k >= 0; k--) begin
            if (cand[k]) begin
                hit_o  = 1'b1;
                rot_o  = ROT_W'(ROT_MIN + k);
                frac_o = frac[k];
            end
        end
    end

endmodule

// File: rtl/imm_expand.sv
module imm_expand
    import imm_codec_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    localparam int CODE_W = $clog2(WORD_W) + BYTE_W - 1
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [WORD_W-1:0] word_o
);

    localparam int ROT_W = $clog2(WORD_W);
    localparam int SEL_W = CODE_W - BYTE_W;
    localparam int LANES = WORD_W / BYTE_W;

    logic [SEL_W-1:0]    sel;
    logic [BYTE_W-1:0]   pay;
    logic                is_rot;
    logic [ROT_W-1:0]    rot_amt;
    logic [WORD_W-1:0]   seed;
    logic [2*WORD_W-1:0] doubled;
    logic [WORD_W-1:0]   w_even;
    logic [WORD_W-1:0]   w_odd;
    logic [WORD_W-1:0]   w_all;

    assign sel     = code_i[CODE_W-1:BYTE_W];
    assign pay     = code_i[BYTE_W-1:0];
    assign is_rot  = |code_i[CODE_W-1:CODE_W-2];
    assign rot_amt = code_i[CODE_W-1 -: ROT_W];
    assign seed    = WORD_W'({1'b1, code_i[BYTE_W-2:0]});
    assign doubled = {seed, seed} >> rot_amt;

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            w_even[l*BYTE_W +: BYTE_W] = (l % 2 == 0) ? pay : '0;
            w_odd [l*BYTE_W +: BYTE_W] = (l % 2 == 1) ? pay : '0;
            w_all [l*BYTE_W +: BYTE_W] = pay;
        end
    end

    always_comb begin
        if (is_rot) begin
            word_o = doubled[WORD_W-1:0];
        end else begin
            unique case (repl_form_e'(sel[1:0]))
                FORM_PLAIN:  word_o = WORD_W'(pay);
                FORM_LANE02: word_o = w_even;
                FORM_LANE13: word_o = w_odd;
                FORM_ALL:    word_o = w_all;
                default:     word_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/imm_operand_codec.sv
module imm_operand_codec
    import imm_codec_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    localparam int CODE_W = $clog2(WORD_W) + BYTE_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [WORD_W-1:0] req_value,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [CODE_W-1:0] rsp_code,
    output logic [WORD_W-1:0] rsp_expanded
);

    localparam int ROT_W = $clog2(WORD_W);
    localparam int SEL_W = CODE_W - BYTE_W;

    codec_state_e      state_q;
    codec_state_e      state_d;
    logic              accept;
    logic              plain_hit;
    logic              even_hit;
    logic              odd_hit;
    logic              all_hit;
    logic              rot_hit;
    logic [ROT_W-1:0]  rot_amt;
    logic [BYTE_W-2:0] rot_frac;
    logic              next_ok;
    logic [CODE_W-1:0] next_code;
    logic              ok_q;
    logic [CODE_W-1:0] code_q;

    assign req_ready = 1'b1;
    assign accept    = req_valid && req_ready;
    assign plain_hit = (req_value[WORD_W-1:BYTE_W] == '0);

    imm_repl_match #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_repl (
        .word_i     (req_value),
        .even_rep_o (even_hit),
        .odd_rep_o  (odd_hit),
        .all_rep_o  (all_hit)
    );

    imm_rot_search #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_rot (
        .word_i (req_value),
        .hit_o  (rot_hit),
        .rot_o  (rot_amt),
        .frac_o (rot_frac)
    );

    // Canonical choice: plain, then replication in selector order, then rotation.
    always_comb begin
        next_ok   = 1'b1;
        next_code = '0;
        if (plain_hit) begin
            next_code = {SEL_W'(FORM_PLAIN), req_value[BYTE_W-1:0]};
        end else if (even_hit) begin
            next_code = {SEL_W'(FORM_LANE02), req_value[BYTE_W-1:0]};
        end else if (odd_hit) begin
            next_code = {SEL_W'(FORM_LANE13), req_value[2*BYTE_W-1:BYTE_W]};
        end else if (all_hit) begin
            next_code = {SEL_W'(FORM_ALL), req_value[BYTE_W-1:0]};
        end else if (rot_hit) begin
            next_code = {rot_amt, rot_frac};
        end else begin
            next_ok   = 1'b0;
        end
    end

    // Transition logic: take / drain.
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = accept ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = accept ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q   <= 1'b0;
            code_q <= '0;
        end else if (accept) begin
            ok_q   <= next_ok;
            code_q <= next_code;
        end
    end

    assign rsp_valid = (state_q == ST_RESULT);
    assign rsp_ok    = ok_q;
    assign rsp_code  = code_q;

    imm_expand #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_expand (
        .code_i (code_q),
        .word_o (rsp_expanded)
    );

    p_valid_after_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);

    p_idle_after_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !rsp_valid);

    p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(rsp_code) && $stable(rsp_ok)));

    p_round_trip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!rsp_ok || rsp_expanded == $past(req_value)));

    p_reject_zero_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> (rsp_code == '0 && rsp_expanded == '0));

    p_zero_canonical_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_value == '0) |=> (rsp_ok && rsp_code == '0));

endmodule

// File: tb/tb_imm_operand_codec.sv
module tb_imm_operand_codec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_value = '0;
    logic        rsp_valid;
    logic        rsp_ok;
    logic [11:0] rsp_code;
    logic [31:0] rsp_expanded;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    // Behavioural model state, updated at each rising edge.
    bit          exp_valid = 1'b0;
    bit          exp_ok = 1'b0;
    logic [11:0] exp_code = '0;
    logic [31:0] exp_word = '0;
    bit          last_take = 1'b0;

    always #10 clk = ~clk;

    imm_operand_codec dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_value    (req_value),
        .rsp_valid    (rsp_valid),
        .rsp_ok       (rsp_ok),
        .rsp_code     (rsp_code),
        .rsp_expanded (rsp_expanded)
    );

    function automatic void ref_encode(input logic [31:0] v, output bit ok,
                                       output logic [11:0] c);
        ok = 1'b1;
        c  = '0;
        if (v[31:8] == 0)                               c = {4'd0, v[7:0]};
        else if (v == {8'h00, v[7:0], 8'h00, v[7:0]})   c = {4'd1, v[7:0]};
        else if (v == {v[15:8], 8'h00, v[15:8], 8'h00}) c = {4'd2, v[15:8]};
        else if (v == {4{v[7:0]}})                      c = {4'd3, v[7:0]};
        else begin
            ok = 1'b0;
            for (int r = 31; r >= 8; r--) begin
                logic [31:0] x;
                x = (v << r) | (v >> (32 - r));
                if (x[31:8] == 0 && x[7]) begin
                    ok = 1'b1;
                    c  = {r[4:0], x[6:0]};
                end
            end
        end
    endfunction

    function automatic logic [31:0] ref_expand(input logic [11:0] c);
        logic [31:0] b;
        int r;
        if (c[11:10] != 2'b00) begin
            r = int'(c[11:7]);
            b = {24'd0, 1'b1, c[6:0]};
            return (b >> r) | (b << (32 - r));
        end
        case (c[9:8])
            2'd0:    return {24'd0, c[7:0]};
            2'd1:    return {8'h00, c[7:0], 8'h00, c[7:0]};
            2'd2:    return {c[7:0], 8'h00, c[7:0], 8'h00};
            default: return {4{c[7:0]}};
        endcase
    endfunction

    function automatic string tag_of(input bit ok, input logic [11:0] c);
        if (!ok)              return "R7";
        if (c[11:10] != 2'b00) return "R5";
        case (c[9:8])
            2'd0:    return "R1";
            2'd1:    return "R2";
            2'd2:    return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Reference model.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_valid = 1'b0;
            exp_ok    = 1'b0;
            exp_code  = '0;
            exp_word  = '0;
            last_take = 1'b0;
        end else if (req_valid) begin
            exp_valid = 1'b1;
            ref_encode(req_value, exp_ok, exp_code);
            exp_word  = exp_ok ? req_value : 32'd0;
            last_take = 1'b1;
        end else begin
            exp_valid = 1'b0;
            last_take = 1'b0;
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (mon_en) begin
            string t;
            t = last_take ? tag_of(exp_ok, exp_code) : "R10";
            check("R9", "rsp_valid", 32'(rsp_valid), 32'(exp_valid));
            check("R9", "req_ready", 32'(req_ready), 32'd1);
            check(t, "rsp_ok", 32'(rsp_ok), 32'(exp_ok));
            check(t, "rsp_code", 32'(rsp_code), 32'(exp_code));
            check("R8", "rsp_expanded", rsp_expanded, exp_word);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
            finish_run();
        end
    end

    task automatic send(input logic [31:0] v);
        @(negedge clk);
        req_valid = 1'b1;
        req_value = v;
        if ($urandom % 5 == 0) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_value = $urandom;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_value = $urandom;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state (R9).
        check("R9", "reset rsp_valid", 32'(rsp_valid), 32'd0);
        check("R9", "reset rsp_ok", 32'(rsp_ok), 32'd0);
        check("R9", "reset rsp_code", 32'(rsp_code), 32'd0);
        mon_en = 1'b1;

        // Zero input canonical code (R6).
        send(32'd0);
        idle();
        check("R6", "zero code", 32'(rsp_code), 32'd0);
        check("R6", "zero ok", 32'(rsp_ok), 32'd1);

        // All plain values (R1).
        for (int i = 0; i < 256; i++) send(32'(i));

        // Replication patterns (R2, R3, R4).
        for (int b = 1; b < 256; b += 7) begin
            send({8'h00, 8'(b), 8'h00, 8'(b)});
            send({8'(b), 8'h00, 8'(b), 8'h00});
            send({4{8'(b)}});
        end
        send(32'hFFFF_FFFF);
        send(32'h0080_0080);
        send(32'h8000_8000);

        // Every seed at every rotate amount (R5).
        for (int r = 8; r < 32; r++) begin
            for (int p = 0; p < 128; p++) begin
                logic [11:0] c;
                c = {5'(r), 7'(p)};
                send(ref_expand(c));
            end
        end

        // Near misses that fit no form (R7).
        send(32'h0000_0101 << 1);
        send(32'h8000_0001);
        send(32'h1234_5678);
        send(32'hFFFF_FFFE);
        send(32'h0001_0002);
        send(32'h0100_0100 | 32'h1);
        send(32'hABAB_ABAA);
        idle();
        idle();

        // Values built from random codes (R8 round trip).
        for (int i = 0; i < 2000; i++) send(ref_expand(12'($urandom)));

        // Raw random words.
        for (int i = 0; i < 2000; i++) send($urandom);

        // Reset in the middle of traffic (R9).
        send(32'h0000_00FF);
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9", "mid-run reset rsp_valid", 32'(rsp_valid), 32'd0);
        check("R9", "mid-run reset rsp_code", 32'(rsp_code), 32'd0);
        rst_n = 1'b1;
        send(32'h3F00_0000);
        idle();
        idle();
        finish_run();
    end

endmodule